// File: doc/BRIEF.md
# Global Event Multicast Mapper

The mapper accepts ingress global events, each tagged with a 16-bit event index, and uses that index to select one entry in a programmable mapping table. Every entry describes two independent egress channels. Each channel either forwards a new 16-bit outgoing event index or is turned off. When a channel's mode flag is set, it instead raises an interrupt-set strobe that carries a register number and a bit number taken from the same index field.

The table is written and read back through a plain word-wide configuration port. Each channel has a valid/ready handshake. An ingress event is taken only when no egress work is left over from the previous event, so the block handles one event at a time. An ingress index that is outside the table is discarded and latches a sticky error flag.

Top module: `gevt_fanout_mapper`

## Requirements
- R1: After reset every table entry reads back as 64'h0000FFFF_0000FFFF, meaning both index fields are 0xFFFF and both mode flags are 0. After reset inReady is 1, no egress valid is high and errFlag is 0.
- R2: A configuration write stores bits 63, 47:32, 31 and 15:0 of cfgWdata. Bits 62:48 and 30:16 read back as 0 whatever was written to them.
- R3: An event is accepted on a clock edge where inValid and inReady are both 1. From the next cycle, channel 0 shows the entry's bits 15:0 on evtIdx[15:0] and channel 1 shows bits 47:32 on evtIdx[31:16], each with its evtValid bit set.
- R4: A channel whose index field equals 0xFFFF produces no valid. If both fields equal 0xFFFF, the event is consumed with no egress activity and inReady stays 1.
- R5: When entry bit 31 is set, channel 0 raises irqValid[0] and not evtValid[0]. It presents entry bits 14:6 on irqReg[8:0] and bits 5:0 on irqBit[5:0].
- R6: When entry bit 63 is set, channel 1 raises irqValid[1] and not evtValid[1]. It presents entry bits 46:38 on irqReg[17:9] and bits 37:32 on irqBit[11:6].
- R7: A channel's valid and payload remain unchanged until egReady for that channel is 1. inReady is 0 while any channel valid is high.
- R8: The two channels complete independently. A channel's valid drops in the cycle after its own handshake, even if the other channel is still stalled.
- R9: An ingress index of DEPTH or more is dropped with no egress valid, and it sets errFlag. errFlag then stays 1 until reset.
- R10: A table write that lands on the same edge as the acceptance of an event for that entry does not affect the accepted event. The next event for that entry uses the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write enable |
| cfgAddr | input | ADDR_W | Table entry address for write and read |
| cfgWdata | input | 64 | Table write data |
| cfgRdata | output | 64 | Entry at cfgAddr, reserved bits zero |
| inValid | input | 1 | Ingress event valid |
| inIdx | input | 16 | Ingress event index |
| inReady | output | 1 | Ingress event may be accepted |
| evtValid | output | 2 | Per-channel outgoing global event valid |
| evtIdx | output | 32 | Outgoing indices, channel 1 in the upper half |
| irqValid | output | 2 | Per-channel interrupt-set strobe valid |
| irqReg | output | 18 | Register numbers, 9 bits per channel |
| irqBit | output | 12 | Bit numbers, 6 bits per channel |
| egReady | input | 2 | Per-channel egress ready |
| errFlag | output | 1 | Sticky out-of-range index flag |

## Verification
There is one register stage from an accepted ingress event to the egress outputs, so valids and payloads are checked in the cycle right after the accept edge. The same holds for clearing a channel: its valid is checked low one cycle after the edge on which egReady was sampled high. The table read port is combinational, so readback is checked in the cycle after the write edge. The bench drives every input on the falling clock edge and samples on the following falling edge, so each check falls exactly one register stage after its cause.

// File: rtl/gevt_pkg.sv
package gevt_pkg;

  localparam logic [15:0] DISABLE_IDX = 16'hFFFF;

  typedef struct packed {
    logic        irqMode;
    logic [15:0] idx;
  } half_t;

  typedef struct packed {
    half_t hi;
    half_t lo;
  } entry_t;

  localparam entry_t RESET_ENTRY = '{hi: '{irqMode: 1'b0, idx: DISABLE_IDX},
                                     lo: '{irqMode: 1'b0, idx: DISABLE_IDX}};

  // control -> datapath
  typedef struct packed {
    logic load;
    logic setErr;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic       inRange;
    logic [1:0] en;
  } lookup_t;

  function automatic logic [63:0] packWord(entry_t e);
    return {e.hi.irqMode, 15'b0, e.hi.idx, e.lo.irqMode, 15'b0, e.lo.idx};
  endfunction

  function automatic entry_t unpackWord(logic [63:0] w);
    entry_t e;
    e.hi.irqMode = w[63];
    e.hi.idx     = w[47:32];
    e.lo.irqMode = w[31];
    e.lo.idx     = w[15:0];
    return e;
  endfunction

endpackage

// File: rtl/gevt_map_datapath.sv
module gevt_map_datapath
  import gevt_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [63:0]       cfgWdata,
  output logic [63:0]       cfgRdata,
  input  logic [15:0]       inIdx,
  input  strobe_t           strobe,
  input  logic [1:0]        pend,
  output lookup_t           lookup,
  output logic [1:0]        evtValid,
  output logic [31:0]       evtIdx,
  output logic [1:0]        irqValid,
  output logic [17:0]       irqReg,
  output logic [11:0]       irqBit
);

  entry_t     tbl [DEPTH];
  entry_t     selEntry;
  half_t      selHalf [2];
  logic [1:0] enVec;
  logic       inRange;
  logic       cfgInRange;
  logic       unusedSink;

  assign inRange    = ({16'b0, inIdx} < 32'(DEPTH));
  assign cfgInRange = (32'(cfgAddr) < 32'(DEPTH));

  // reserved write bits and the error strobe have no use here
  assign unusedSink = ^{cfgWdata[62:48], cfgWdata[30:16], strobe.setErr};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= RESET_ENTRY;
    end else if (cfgWe && cfgInRange) begin
      tbl[cfgAddr] <= unpackWord(cfgWdata);
    end
  end

  assign cfgRdata = cfgInRange ? packWord(tbl[cfgAddr]) : 64'b0;

  assign selEntry   = inRange ? tbl[inIdx[ADDR_W-1:0]] : RESET_ENTRY;
  assign selHalf[0] = selEntry.lo;
  assign selHalf[1] = selEntry.hi;

  for (genvar k = 0; k < 2; k++) begin : g_ch
    half_t heldQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            heldQ <= RESET_ENTRY.lo;
      else if (strobe.load) heldQ <= selHalf[k];
    end

    assign enVec[k]          = (selHalf[k].idx != DISABLE_IDX);
    assign evtValid[k]       = pend[k] & ~heldQ.irqMode;
    assign irqValid[k]       = pend[k] &  heldQ.irqMode;
    assign evtIdx[16*k +: 16] = heldQ.idx;
    assign irqReg[9*k +: 9]   = heldQ.idx[14:6];
    assign irqBit[6*k +: 6]   = heldQ.idx[5:0];
  end

  assign lookup = '{inRange: inRange, en: enVec};

endmodule

// File: rtl/gevt_map_ctrl.sv
module gevt_map_ctrl
  import gevt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  lookup_t    lookup,
  input  logic [1:0] egReady,
  output logic       inReady,
  output strobe_t    strobe,
  output logic [1:0] pend,
  output logic       errFlag
);

  logic [1:0] pendQ;
  logic       errQ;
  logic       accept;

  assign inReady       = ~|pendQ;
  assign accept        = inValid & inReady;
  assign strobe.load   = accept &  lookup.inRange;
  assign strobe.setErr = accept & ~lookup.inRange;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 2'b00;
      errQ  <= 1'b0;
    end else begin
      errQ <= errQ | strobe.setErr;
      if (strobe.load) pendQ <= lookup.en;
      else             pendQ <= pendQ & ~egReady;
    end
  end

  assign pend    = pendQ;
  assign errFlag = errQ;

endmodule

// File: rtl/gevt_fanout_mapper.sv
module gevt_fanout_mapper
  import gevt_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [63:0]       cfgWdata,
  output logic [63:0]       cfgRdata,
  input  logic              inValid,
  input  logic [15:0]       inIdx,
  output logic              inReady,
  output logic [1:0]        evtValid,
  output logic [31:0]       evtIdx,
  output logic [1:0]        irqValid,
  output logic [17:0]       irqReg,
  output logic [11:0]       irqBit,
  input  logic [1:0]        egReady,
  output logic              errFlag
);

  strobe_t    strobe;
  lookup_t    lookup;
  logic [1:0] pend;

  gevt_map_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .lookup  (lookup),
    .egReady (egReady),
    .inReady (inReady),
    .strobe  (strobe),
    .pend    (pend),
    .errFlag (errFlag)
  );

  gevt_map_datapath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .inIdx    (inIdx),
    .strobe   (strobe),
    .pend     (pend),
    .lookup   (lookup),
    .evtValid (evtValid),
    .evtIdx   (evtIdx),
    .irqValid (irqValid),
    .irqReg   (irqReg),
    .irqBit   (irqBit)
  );

endmodule

// File: rtl/gevt_mapper_chk.sv
module gevt_mapper_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [15:0] inIdx,
  input logic        inReady,
  input logic [1:0]  evtValid,
  input logic [31:0] evtIdx,
  input logic [1:0]  irqValid,
  input logic [1:0]  egReady,
  input logic        errFlag
);

  // R7
  hold_ch0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid[0] && !egReady[0]) |=> (evtValid[0] && $stable(evtIdx[15:0])));

  // R7
  hold_ch1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid[1] && !egReady[1]) |=> (evtValid[1] && $stable(evtIdx[31:16])));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtValid) || (|irqValid)) |-> !inReady);

  // R4
  no_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid[0] |-> evtIdx[15:0] != 16'hFFFF) and (evtValid[1] |-> evtIdx[31:16] != 16'hFFFF));

  // R5
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(evtValid & irqValid) == 0);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ({16'b0, inIdx} >= 32'(DEPTH))) |=> (evtValid == 2'b00 && irqValid == 2'b00 && errFlag));

endmodule

bind gevt_fanout_mapper gevt_mapper_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inIdx    (inIdx),
  .inReady  (inReady),
  .evtValid (evtValid),
  .evtIdx   (evtIdx),
  .irqValid (irqValid),
  .egReady  (egReady),
  .errFlag  (errFlag)
);

// File: tb/test_gevt_fanout_mapper.sv
`timescale 1ns/1ps
module test_gevt_fanout_mapper;

  localparam int DEPTH  = 64;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWe = 1'b0;
  logic [ADDR_W-1:0] cfgAddr = '0;
  logic [63:0]       cfgWdata = '0;
  logic [63:0]       cfgRdata;
  logic              inValid = 1'b0;
  logic [15:0]       inIdx = '0;
  logic              inReady;
  logic [1:0]        evtValid;
  logic [31:0]       evtIdx;
  logic [1:0]        irqValid;
  logic [17:0]       irqReg;
  logic [11:0]       irqBit;
  logic [1:0]        egReady = 2'b00;
  logic              errFlag;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gevt_fanout_mapper #(.DEPTH(DEPTH)) i_gevt_fanout_mapper (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .inValid(inValid), .inIdx(inIdx), .inReady(inReady),
    .evtValid(evtValid), .evtIdx(evtIdx), .irqValid(irqValid), .irqReg(irqReg),
    .irqBit(irqBit), .egReady(egReady), .errFlag(errFlag)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(logic [ADDR_W-1:0] a, logic [63:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic sendEvt(logic [15:0] idx);
    @(negedge clk);
    inValid = 1'b1; inIdx = idx;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic drain();
    egReady = 2'b11;
    @(negedge clk);
    egReady = 2'b00;
  endtask

  task automatic testReset();
    cfgAddr = 6'd0;
    #1;
    chk("R1 readback", cfgRdata, 64'h0000FFFF_0000FFFF);
    chk("R1 inReady", 64'(inReady), 64'd1);
    chk("R1 valids", 64'({evtValid, irqValid}), 64'd0);
    chk("R1 errFlag", 64'(errFlag), 64'd0);
  endtask

  task automatic testCfg();
    cfgWrite(6'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R2 reserved masked", cfgRdata, 64'h8000FFFF_8000FFFF);
    cfgWrite(6'd3, 64'h0001_2345_0000_6789);
    chk("R2 plain write", cfgRdata, 64'h00002345_00006789);
  endtask

  task automatic testFanout();
    cfgWrite(6'd1, 64'h00001234_00000042);
    sendEvt(16'd1);
    chk("R3 both valid", 64'(evtValid), 64'd3);
    chk("R3 ch0 idx", 64'(evtIdx[15:0]), 64'h0042);
    chk("R3 ch1 idx", 64'(evtIdx[31:16]), 64'h1234);
    chk("R7 stall", 64'(inReady), 64'd0);
    @(negedge clk);
    chk("R7 hold", 64'({evtValid, evtIdx}), {30'd0, 2'b11, 32'h1234_0042});
    egReady = 2'b01;
    @(negedge clk);
    egReady = 2'b00;
    chk("R8 ch0 done ch1 held", 64'(evtValid), 64'd2);
    chk("R8 still stalled", 64'(inReady), 64'd0);
    @(negedge clk);
    chk("R8 ch1 held", 64'({evtValid, evtIdx[31:16]}), {46'd0, 2'b10, 16'h1234});
    egReady = 2'b10;
    @(negedge clk);
    egReady = 2'b00;
    chk("R8 all done", 64'({inReady, evtValid}), 64'b100);
  endtask

  task automatic testDisable();
    cfgWrite(6'd2, 64'h00000007_0000FFFF);
    sendEvt(16'd2);
    chk("R4 single disable valid", 64'(evtValid), 64'd2);
    chk("R4 single disable idx", 64'(evtIdx[31:16]), 64'h0007);
    drain();
    sendEvt(16'd0);
    chk("R4 dual disable no valid", 64'({evtValid, irqValid}), 64'd0);
    chk("R4 dual disable ready", 64'(inReady), 64'd1);
  endtask

  task automatic testIrq();
    cfgWrite(6'd4, 64'h0000FFFF_8000556A);
    sendEvt(16'd4);
    chk("R5 valids", 64'({evtValid, irqValid}), 64'b0001);
    chk("R5 reg", 64'(irqReg[8:0]), 64'h155);
    chk("R5 bit", 64'(irqBit[5:0]), 64'h2A);
    drain();
    cfgWrite(6'd6, 64'h80003CD1_0000FFFF);
    sendEvt(16'd6);
    chk("R6 valids", 64'({evtValid, irqValid}), 64'b0010);
    chk("R6 reg", 64'(irqReg[17:9]), 64'h0F3);
    chk("R6 bit", 64'(irqBit[11:6]), 64'h11);
    drain();
  endtask

  task automatic testRange();
    sendEvt(16'd64);
    chk("R9 no valid", 64'({evtValid, irqValid}), 64'd0);
    chk("R9 err set", 64'(errFlag), 64'd1);
    chk("R9 ready", 64'(inReady), 64'd1);
  endtask

  task automatic testWriteRace();
    cfgWrite(6'd5, 64'h0000FFFF_00000AAA);
    @(negedge clk);
    inValid = 1'b1; inIdx = 16'd5;
    cfgWe = 1'b1; cfgAddr = 6'd5; cfgWdata = 64'h0000FFFF_00000BBB;
    @(negedge clk);
    inValid = 1'b0; cfgWe = 1'b0;
    chk("R10 old mapping", 64'({evtValid, evtIdx[15:0]}), {46'd0, 2'b01, 16'h0AAA});
    drain();
    sendEvt(16'd5);
    chk("R10 new mapping", 64'({evtValid, evtIdx[15:0]}), {46'd0, 2'b01, 16'h0BBB});
    drain();
    chk("R9 err still set", 64'(errFlag), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCfg();
    testFanout();
    testDisable();
    testIrq();
    testRange();
    testWriteRace();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      nVec++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule